// File: doc/BRIEF.md
# Cascaded Programmable Clock Prescaler

The prescaler derives two clock-enable streams from a single main clock. The first stage divides the main clock by 1, 2 or 4 to make the peripheral tick. The second stage counts peripheral ticks and either passes them through or divides them by a further 4 to make the CPU tick. The resulting CPU rates are main/1, main/2, main/4 (reachable two ways), main/8 and main/16.

Both outputs are enables in the main clock domain. Each is high for exactly one main-clock cycle per divided period, and it is held high continuously when its overall ratio is 1. Two 8-bit registers on a small memory-mapped bus set the ratios. Each register accepts either a whole-byte write or a single-bit set or clear. A ratio change waits for the end of the current divided period, so no period is cut short or run together with the next.

Top module: `cprs_top`

## Requirements
- R1: After reset both registers read 02H, the peripheral tick runs at main/4 and the CPU tick at main/16. The first peripheral tick occurs in the 4th cycle after reset is released and the first CPU tick in the 16th.
- R2: The peripheral register sits at address FFF3H. Bits 1:0 hold the stage code: 00 gives main/1, 01 gives main/2 and 10 gives main/4. Bits 7:2 read as 0.
- R3: The CPU register sits at address FFFBH. Bit 1 selects the second stage: 0 makes the CPU tick equal to the peripheral tick, and 1 divides the peripheral tick by 4. All other bits read as 0.
- R4: A byte write that would load code 11 into the peripheral register is ignored, and the register keeps its previous value and ratio.
- R5: A bit write (bit index 0..7, bit value) changes only the addressed bit. A bit write that would form code 11 is ignored, and a bit write to an unused bit position has no effect.
- R6: Writes to any other address change neither register, and reads of any other address return 00H.
- R7: A new ratio takes effect at the next boundary of the current divided period. Every interval between successive ticks equals either the old or the new period, and once a new-period interval has appeared no old-period interval follows.
- R8: When the ratio is above 1, each tick is exactly one main-clock cycle wide. When the ratio is 1, the tick is held high.
- R9: A CPU tick only ever occurs in a cycle that also carries a peripheral tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Byte write data |
| bus_wr_byte | input | 1 | Whole-byte write strobe |
| bus_wr_bit | input | 1 | Single-bit write strobe |
| bus_bit_idx | input | 3 | Bit position for a single-bit write |
| bus_bit_val | input | 1 | Value written by a single-bit write |
| bus_rdata | output | 8 | Read data for the addressed register |
| peri_tick | output | 1 | Peripheral clock enable |
| cpu_tick | output | 1 | CPU clock enable |

## Verification
A corrupted control register shows on the read port in the cycle after the write. It also shows at the tick outputs within two full periods of the longest ratio, about 32 main cycles, because the active ratio is only reloaded at a period boundary. A stage counter or active-ratio state that is wrong shows as a tick interval that is neither the old nor the new period. It can also show as a doubled-width tick, or as a CPU tick without a matching peripheral tick. The interval checks around each ratio change catch this within one period.

// File: rtl/cprs_pkg.sv
`timescale 1ns/1ps
package cprs_pkg;
    localparam int DATA_W   = 8;
    localparam int CODE_W   = 2;
    localparam int STAGE_KW = 2;

    typedef logic [CODE_W-1:0] peri_code_t;

    localparam peri_code_t PERI_RSVD  = 2'b11;
    localparam peri_code_t PERI_RESET = 2'b10;
    localparam int         CPU_BIT    = 1;
    localparam int         CPU_DIV_K  = 2;

    typedef struct packed {
        peri_code_t peri_code;
        logic       cpu_div4;
    } ctl_regs_t;
endpackage

// File: rtl/cprs_regs.sv
`timescale 1ns/1ps
module cprs_regs
    import cprs_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter [ADDR_W-1:0] PERI_ADDR = 16'hFFF3,
    parameter [ADDR_W-1:0] CPU_ADDR  = 16'hFFFB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr_byte,
    input  logic              bus_wr_bit,
    input  logic [2:0]        bus_bit_idx,
    input  logic              bus_bit_val,
    output logic [DATA_W-1:0] bus_rdata,
    output peri_code_t        peri_code,
    output logic              cpu_div4
);
    ctl_regs_t  regs_d, regs_q;
    peri_code_t cand;
    logic       peri_hit, cpu_hit, any_wr;

    always_comb begin
        regs_d   = regs_q;
        peri_hit = (bus_addr == PERI_ADDR);
        cpu_hit  = (bus_addr == CPU_ADDR);
        any_wr   = bus_wr_byte || bus_wr_bit;

        // candidate code for the first stage
        cand = regs_q.peri_code;
        if (bus_wr_byte) begin
            cand = bus_wdata[CODE_W-1:0];
        end else if (bus_wr_bit && (int'(bus_bit_idx) < CODE_W)) begin
            cand[bus_bit_idx[0]] = bus_bit_val;
        end
        if (peri_hit && any_wr && (cand != PERI_RSVD)) begin
            regs_d.peri_code = cand;
        end

        if (cpu_hit && bus_wr_byte) begin
            regs_d.cpu_div4 = bus_wdata[CPU_BIT];
        end else if (cpu_hit && bus_wr_bit && (int'(bus_bit_idx) == CPU_BIT)) begin
            regs_d.cpu_div4 = bus_bit_val;
        end

        bus_rdata = '0;
        if (peri_hit) begin
            bus_rdata[CODE_W-1:0] = regs_q.peri_code;
        end else if (cpu_hit) begin
            bus_rdata[CPU_BIT] = regs_q.cpu_div4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{peri_code: PERI_RESET, cpu_div4: 1'b1};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign peri_code = regs_q.peri_code;
    assign cpu_div4  = regs_q.cpu_div4;

    // R4: reserved code never reaches the register
    a_r4_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.peri_code != PERI_RSVD);

    // R6: foreign address writes leave state alone
    a_r6_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && !peri_hit && !cpu_hit) |=> $stable(regs_q));

    // R5: bit writes to unused CPU register bits leave the divide bit alone
    a_r5_cpu_unused_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_bit && !bus_wr_byte && cpu_hit && (int'(bus_bit_idx) != CPU_BIT))
        |=> $stable(regs_q.cpu_div4));
endmodule

// File: rtl/cprs_div_stage.sv
`timescale 1ns/1ps
module cprs_div_stage #(
    parameter int MAX_K = 2,
    parameter int K_W   = 2,
    parameter int RST_K = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_en,
    input  logic [K_W-1:0] req_k,
    output logic           en_o
);
    localparam int CNT_W = (MAX_K < 1) ? 1 : MAX_K;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [K_W-1:0]   act_k;
    } stage_t;

    stage_t           st_d, st_q;
    logic [CNT_W-1:0] last_cnt;
    logic             at_end;

    always_comb begin
        st_d     = st_q;
        last_cnt = CNT_W'((32'd1 << st_q.act_k) - 32'd1);
        at_end   = (st_q.cnt == last_cnt);
        en_o     = in_en && at_end;
        if (in_en) begin
            if (at_end) begin
                st_d.cnt   = '0;
                st_d.act_k = req_k;   // ratio reloads only on a period boundary
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, act_k: K_W'(RST_K)};
        end else begin
            st_q <= st_d;
        end
    end

    // R7: active ratio changes only at a period boundary
    a_r7_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_en && at_end) |=> $stable(st_q.act_k));

    // R7: count stays inside the active period
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_cnt);

    // R2: requested exponent is always a supported one
    a_r2_req_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(req_k) <= MAX_K);

    // R8: ticks are one cycle wide when the ratio exceeds 1
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && (st_q.act_k != '0) && (req_k != '0)) |=> !en_o);
endmodule

// File: rtl/cprs_top.sv
`timescale 1ns/1ps
module cprs_top
    import cprs_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter [ADDR_W-1:0] PERI_ADDR = 16'hFFF3,
    parameter [ADDR_W-1:0] CPU_ADDR  = 16'hFFFB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr_byte,
    input  logic              bus_wr_bit,
    input  logic [2:0]        bus_bit_idx,
    input  logic              bus_bit_val,
    output logic [7:0]        bus_rdata,
    output logic              peri_tick,
    output logic              cpu_tick
);
    localparam int PERI_MAX_K = 2;
    localparam int PERI_RST_K = int'(PERI_RESET);

    peri_code_t         peri_code;
    logic               cpu_div4;
    logic [STAGE_KW-1:0] cpu_k;

    cprs_regs #(
        .ADDR_W    (ADDR_W),
        .PERI_ADDR (PERI_ADDR),
        .CPU_ADDR  (CPU_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr_byte (bus_wr_byte),
        .bus_wr_bit  (bus_wr_bit),
        .bus_bit_idx (bus_bit_idx),
        .bus_bit_val (bus_bit_val),
        .bus_rdata   (bus_rdata),
        .peri_code   (peri_code),
        .cpu_div4    (cpu_div4)
    );

    cprs_div_stage #(
        .MAX_K (PERI_MAX_K),
        .K_W   (STAGE_KW),
        .RST_K (PERI_RST_K)
    ) u_peri_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .in_en (1'b1),
        .req_k (STAGE_KW'(peri_code)),
        .en_o  (peri_tick)
    );

    assign cpu_k = cpu_div4 ? STAGE_KW'(CPU_DIV_K) : '0;

    cprs_div_stage #(
        .MAX_K (CPU_DIV_K),
        .K_W   (STAGE_KW),
        .RST_K (CPU_DIV_K)
    ) u_cpu_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .in_en (peri_tick),
        .req_k (cpu_k),
        .en_o  (cpu_tick)
    );

    // R9: CPU tick coincides with a peripheral tick
    a_r9_cpu_in_peri: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tick |-> peri_tick);
endmodule

// File: tb/cprs_top_tb.sv
`timescale 1ns/1ps
module cprs_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr_byte = 1'b0;
    logic        bus_wr_bit = 1'b0;
    logic [2:0]  bus_bit_idx = '0;
    logic        bus_bit_val = 1'b0;
    logic [7:0]  bus_rdata;
    logic        peri_tick, cpu_tick;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [15:0] A_PERI = 16'hFFF3;
    localparam logic [15:0] A_CPU  = 16'hFFFB;

    always #2.5 clk = ~clk;

    cprs_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr_byte(bus_wr_byte), .bus_wr_bit(bus_wr_bit),
        .bus_bit_idx(bus_bit_idx), .bus_bit_val(bus_bit_val),
        .bus_rdata(bus_rdata), .peri_tick(peri_tick), .cpu_tick(cpu_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_byte = 1'b1;
        @(negedge clk);
        bus_wr_byte = 1'b0;
    endtask

    task automatic wr_bit(input logic [15:0] a, input int idx, input logic v);
        @(negedge clk);
        bus_addr = a; bus_bit_idx = 3'(idx); bus_bit_val = v; bus_wr_bit = 1'b1;
        @(negedge clk);
        bus_wr_bit = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input int exp, input string req);
        bus_addr = a;
        #1;
        chk(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
    endtask

    // steady-state rate check over a 64-cycle window
    task automatic measure(input int p_div, input int c_div, input string req);
        int p_last = -1, c_last = -1, p_cnt = 0, c_cnt = 0, p_bad = 0, c_bad = 0;
        repeat (48) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); #1;
            if (peri_tick) begin
                if (p_last >= 0 && (i - p_last) != p_div) p_bad = i - p_last;
                p_last = i; p_cnt++;
            end
            if (cpu_tick) begin
                if (!peri_tick) c_bad = -1;   // R9
                if (c_last >= 0 && (i - c_last) != c_div) c_bad = i - c_last;
                c_last = i; c_cnt++;
            end
        end
        chk(p_cnt == 64 / p_div && p_bad == 0, {req, " peri rate"}, p_cnt, 64 / p_div);
        chk(c_cnt == 64 / c_div && c_bad == 0, {req, " cpu rate"},  c_cnt, 64 / c_div);
    endtask

    // transition check; kind 0 = peri byte write, 1 = cpu byte write
    task automatic trans(input int kind, input logic [7:0] val, input int oldv, input int newv);
        int last = 0, bad = 0, seen_new = 0;
        repeat (48) @(negedge clk);
        do begin @(negedge clk); #1; end while (!(kind == 0 ? peri_tick : cpu_tick));
        fork
            begin
                if (kind == 0) wr_byte(A_PERI, val); else wr_byte(A_CPU, val);
            end
            begin
                for (int i = 1; i <= 80; i++) begin
                    @(negedge clk); #1;
                    if (kind == 0 ? peri_tick : cpu_tick) begin
                        if (i - last == newv) seen_new = 1;
                        else if (i - last != oldv || seen_new != 0) bad = i - last;
                        last = i;
                    end
                end
            end
        join
        chk(bad == 0 && seen_new == 1, "R7 boundary change", bad, 0);
    endtask

    task automatic t_reset();
        int p_first = -1, c_first = -1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (peri_tick && p_first < 0) p_first = i;
            if (cpu_tick && c_first < 0) c_first = i;
            @(negedge clk);
        end
        chk(p_first == 3,  "R1 first peri tick", p_first, 3);
        chk(c_first == 15, "R1 first cpu tick",  c_first, 15);
        rd_chk(A_PERI, 8'h02, "R1 peri reset value");
        rd_chk(A_CPU,  8'h02, "R1 cpu reset value");
        measure(4, 16, "R1");
    endtask

    task automatic t_ratios();
        wr_byte(A_CPU, 8'h00);
        rd_chk(A_CPU, 8'h00, "R3 cpu bit clear");
        wr_byte(A_PERI, 8'hFC);               // code 00, upper bits dropped
        rd_chk(A_PERI, 8'h00, "R2 upper bits read 0");
        measure(1, 1, "R8 ratio 1 held high");
        wr_byte(A_PERI, 8'h01);
        measure(2, 2, "R2 code 01");
        wr_byte(A_PERI, 8'h02);
        measure(4, 4, "R2 code 10");
        wr_byte(A_CPU, 8'hFF);
        rd_chk(A_CPU, 8'h02, "R3 only bit1 reads");
        measure(4, 16, "R3 div4");
        wr_byte(A_PERI, 8'h01);
        measure(2, 8, "R3 fx/8");
        wr_byte(A_PERI, 8'h00);
        measure(1, 4, "R3 fx/4 second way");
    endtask

    task automatic t_reserved();
        wr_byte(A_PERI, 8'h01);
        wr_byte(A_PERI, 8'hFF);
        rd_chk(A_PERI, 8'h01, "R4 reserved byte ignored");
        measure(2, 8, "R4 ratio kept");
    endtask

    task automatic t_bits();
        wr_bit(A_PERI, 1, 1'b1);              // 01 -> 11 rejected
        rd_chk(A_PERI, 8'h01, "R5 bit write to 11 ignored");
        wr_bit(A_PERI, 0, 1'b0);              // 01 -> 00
        rd_chk(A_PERI, 8'h00, "R5 clear bit0");
        wr_bit(A_PERI, 1, 1'b1);              // 00 -> 10
        rd_chk(A_PERI, 8'h02, "R5 set bit1");
        wr_bit(A_PERI, 5, 1'b1);
        rd_chk(A_PERI, 8'h02, "R5 unused peri bit");
        wr_bit(A_CPU, 0, 1'b1);
        rd_chk(A_CPU, 8'h02, "R5 unused cpu bit");
        wr_bit(A_CPU, 1, 1'b0);
        rd_chk(A_CPU, 8'h00, "R5 cpu bit clear");
        measure(4, 4, "R5 ratio after bit writes");
    endtask

    task automatic t_foreign();
        wr_byte(16'hFFF4, 8'h01);
        wr_bit(16'hFFFA, 1, 1'b1);
        rd_chk(16'hFFF4, 8'h00, "R6 foreign read");
        rd_chk(A_PERI, 8'h02, "R6 peri untouched");
        rd_chk(A_CPU,  8'h00, "R6 cpu untouched");
    endtask

    task automatic t_change();
        trans(0, 8'h01, 4, 2);                // peri /4 -> /2
        trans(0, 8'h02, 2, 4);                // peri /2 -> /4
        trans(1, 8'h02, 4, 16);               // cpu /4 -> /16
        trans(1, 8'h00, 16, 4);               // cpu /16 -> /4
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_ratios();
        t_reserved();
        t_bits();
        t_foreign();
        t_change();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule